// File: doc/BRIEF.md
# Buffered Full-Duplex SPI Burst Master

This block is an SPI bus master that is controlled through a simple register bus. It runs an entire transfer out of one internal byte buffer. The host loads up to DEPTH bytes into the buffer and then writes a single control word. That word gives the byte count, the start command, and whether the chip-select line is released when the burst ends. The engine shifts every byte out on MOSI and takes in a byte from MISO at the same time. Each received byte is written back into the buffer slot that held the byte just sent, so when the burst finishes the buffer holds the reply.

A long transaction can span several bursts. Chip select stays low between bursts until a burst flagged as final completes. The host can also release chip select at any idle moment, which resets the bus before a new message. When a burst completes, a sticky completion flag is set. That flag can drive an interrupt line through an enable bit.

Top module: `spi_burst_master`

## Requirements
- R1: Byte addresses 0 to DEPTH-1 reach the buffer (data in bits [7:0], read back zero-extended). Address DEPTH holds the control/status word and address DEPTH+2 holds the clock divider. Both are readable and writable while idle.
- R2: Control word fields are as follows. Bits [9:0] hold the length. Bit 12 is the completion flag. Bit 13 is the interrupt enable. Bit 14 is the final/release flag. Bit 15 is start on write and busy on read. Reset leaves all of them 0, with chip select high, SCK low and irq low.
- R3: Bytes go out MSB first on MOSI. After the burst, buffer byte k holds the byte received, MSB first, during the transmission of byte k.
- R4: A burst produces exactly 8·N rising SCK edges, where N is the length field. A length field of 0 gives DEPTH bytes.
- R5: Chip select stays low for the whole burst. At the end it goes high only if the burst was started with bit 14 set. Otherwise it stays low, and the next burst continues the same transaction.
- R6: An idle control write with bit 14 set and bit 15 clear drives chip select high and starts no burst.
- R7: The bus runs in SPI mode 0. SCK is low whenever chip select is high. MOSI never changes in the clock cycle in which SCK rises, and MISO is captured on that rise.
- R8: Each SCK half period lasts divider+1 system clock cycles. Divider writes made while busy are ignored.
- R9: When a burst ends, busy clears and the completion flag sets in the same cycle. Writing 1 to bit 12 clears the flag. Writing 0 to bit 12 leaves it unchanged.
- R10: irq is high exactly when both the completion flag and the interrupt enable are set.
- R11: While busy, the following have no effect: buffer writes, a second start, and release requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | AW+1 | Byte address on the register bus |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| sck | output | 1 | SPI clock, idles low |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| cs_n | output | 1 | Active-low chip select |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest case to reach is a chip select held across several bursts. Here the received data of a later burst must continue the slave's byte stream rather than restart it. The bench's slave model counts bytes from the moment chip select falls and resets its count only when chip select rises. Sweeping bursts with the final flag cleared therefore exposes any release or restart that should not happen. A second hard case is a host write arriving in the middle of a burst. The bench reaches it by issuing buffer writes and a second start while it polls the busy bit, and then checks that the targeted slot holds the received byte.

// File: rtl/spi_burst_master.sv
module spi_burst_master #(
  parameter int DEPTH = 1024,
  parameter int DIVW  = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int BAW  = AW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [BAW-1:0]  bus_addr,
  input  logic            bus_we,
  input  logic [15:0]     bus_wdata,
  output logic [15:0]     bus_rdata,
  output logic            sck,
  output logic            mosi,
  input  logic            miso,
  output logic            cs_n,
  output logic            irq
);

  logic [7:0]      mem [DEPTH];
  logic            busy, flag, ien, last_q;
  logic [AW-1:0]   len_q, idx;
  logic [2:0]      bitc;
  logic [DIVW-1:0] div_q, dcnt;
  logic [7:0]      txs, rxs;

  wire is_buf   = !bus_addr[AW];
  wire is_ctl   = bus_addr == BAW'(DEPTH);
  wire is_div   = bus_addr == BAW'(DEPTH + 2);
  wire ctl_wr   = bus_we && is_ctl;
  wire start    = ctl_wr && bus_wdata[15] && !busy;
  wire tick     = busy && (dcnt == div_q);
  wire rise     = tick && !sck;
  wire fall     = tick && sck;
  wire byte_end = fall && (bitc == 3'd7);
  wire done     = byte_end && (idx == len_q - AW'(1));

  assign mosi = txs[7];
  assign irq  = flag && ien;

  always_comb begin
    if (is_buf)      bus_rdata = {8'h00, mem[bus_addr[AW-1:0]]};
    else if (is_ctl) bus_rdata = {busy, last_q, ien, flag, 12'(len_q)};
    else if (is_div) bus_rdata = 16'(div_q);
    else             bus_rdata = '0;
  end

  always_ff @(posedge clk) begin
    if (bus_we && is_buf && !busy) mem[bus_addr[AW-1:0]] <= bus_wdata[7:0];
    else if (byte_end)             mem[idx] <= rxs;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; flag <= 1'b0; ien <= 1'b0; last_q <= 1'b0;
      len_q <= '0; idx <= '0; bitc <= '0; div_q <= '0; dcnt <= '0;
      txs <= '0; rxs <= '0; sck <= 1'b0; cs_n <= 1'b1;
    end else begin
      dcnt <= (!busy || tick) ? '0 : dcnt + DIVW'(1);
      if (bus_we && is_div && !busy) div_q <= bus_wdata[DIVW-1:0];
      if (ctl_wr) begin
        ien <= bus_wdata[13];
        if (bus_wdata[12]) flag <= 1'b0;
        if (!busy && bus_wdata[14] && !bus_wdata[15]) cs_n <= 1'b1;
      end
      if (start) begin
        busy   <= 1'b1;
        len_q  <= bus_wdata[AW-1:0];
        last_q <= bus_wdata[14];
        idx    <= '0;
        bitc   <= '0;
        cs_n   <= 1'b0;
        txs    <= mem[0];
      end
      if (rise) begin
        sck <= 1'b1;
        rxs <= {rxs[6:0], miso};
      end
      if (fall) begin
        sck <= 1'b0;
        if (byte_end) begin
          bitc <= '0;
          if (done) begin
            busy <= 1'b0;
            flag <= 1'b1;
            if (last_q) cs_n <= 1'b1;
          end else begin
            idx <= idx + AW'(1);
            txs <= mem[idx + AW'(1)];
          end
        end else begin
          bitc <= bitc + 3'd1;
          txs  <= {txs[6:0], 1'b0};
        end
      end
    end
  end

  AST_SCK_IDLE_LOW:   assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sck);                 // R7
  AST_MOSI_ON_RISE:   assert property (@(posedge clk) disable iff (!rst_n) $rose(sck) |-> $stable(mosi));  // R7
  AST_CS_IN_BURST:    assert property (@(posedge clk) disable iff (!rst_n) busy |-> !cs_n);                // R5
  AST_CS_RELEASE:     assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) && last_q |-> cs_n);   // R5
  AST_CS_KEEP:        assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) && !last_q |-> !cs_n); // R5
  AST_FLAG_AT_END:    assert property (@(posedge clk) disable iff (!rst_n) $rose(flag) |-> $fell(busy));   // R9
  AST_DIV_FROZEN:     assert property (@(posedge clk) disable iff (!rst_n) busy && $past(busy) |-> $stable(div_q)); // R8

endmodule

// File: tb/spi_burst_master_tb.sv
module spi_burst_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 1024;
  localparam int AW = $clog2(DEPTH);
  localparam int BAW = AW + 1;
  localparam int CTRL = DEPTH;
  localparam int DIVA = DEPTH + 2;

  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0, miso;
  logic [BAW-1:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic sck, mosi, cs_n, irq;

  int vecs = 0, errs = 0;
  int cyc = 0;
  int slave_n = 0, slave_b = 0, rises = 0, t_prev = 0, t_last = 0;
  logic [7:0] shreg = '0;
  logic [7:0] cap [2048];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_burst_master #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck(sck), .mosi(mosi),
    .miso(miso), .cs_n(cs_n), .irq(irq));

  function automatic logic [7:0] g(input int n);
    return 8'((n * 37 + 11) & 255);
  endfunction

  assign miso = g(slave_n)[7 - slave_b];

  always @(posedge sck or posedge cs_n) begin
    if (cs_n) begin
      slave_n <= 0; slave_b <= 0;
    end else begin
      shreg <= {shreg[6:0], mosi};
      rises <= rises + 1;
      t_prev <= t_last; t_last <= cyc;
      if (slave_b == 7) begin
        if (slave_n < 2048) cap[slave_n] <= {shreg[6:0], mosi};
        slave_n <= slave_n + 1; slave_b <= 0;
      end else slave_b <= slave_b + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); bus_addr = BAW'(a); bus_wdata = 16'(d); bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    @(negedge clk); bus_addr = BAW'(a); #1 d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    int n = 0;
    do begin rd(CTRL, s); n++; end while (s[15] && n < 40000);
    chk(n < 40000, "R9 busy clears", int'(s), 0);
  endtask

  task automatic run_burst(input int len, input bit last, input int dv, input int seed);
    int eff = (len == 0) ? DEPTH : len;
    int n0, r0;
    logic [15:0] d;
    wr(DIVA, dv);
    for (int i = 0; i < eff; i++) wr(i, (i * 13 + seed) & 255);
    n0 = slave_n; r0 = rises;
    wr(CTRL, 16'h8000 | 16'h2000 | (last ? 16'h4000 : 16'h0) | (len & 16'h3FF));
    wait_idle();
    chk(rises - r0 == 8 * eff, "R4 edge count", rises - r0, 8 * eff);
    chk(t_last - t_prev == 2 * (dv + 1), "R8 period", t_last - t_prev, 2 * (dv + 1));
    for (int i = 0; i < eff; i++) begin
      chk(cap[n0 + i] == 8'((i * 13 + seed) & 255), "R3 mosi byte", cap[n0 + i], (i * 13 + seed) & 255);
      rd(i, d);
      chk(d == {8'h0, g(n0 + i)}, "R3 rx in place", d, g(n0 + i));
    end
    chk(cs_n == last, "R5 cs at end", cs_n, last);
    rd(CTRL, d);
    chk(d[12] && irq, "R9 R10 flag+irq", {d[12], irq}, 3);
    wr(CTRL, 16'h1000);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errs++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(CTRL, d);
    chk(d == 16'h0, "R2 reset status", d, 0);
    chk(cs_n && !sck && !irq, "R2 reset pins", {cs_n, sck, irq}, 4);

    wr(0, 16'h5A); wr(DEPTH - 1, 16'hFFC3); wr(DIVA, 16'h0007);
    rd(0, d);         chk(d == 16'h005A, "R1 buf lo", d, 16'h5A);
    rd(DEPTH - 1, d); chk(d == 16'h00C3, "R1 buf hi", d, 16'hC3);
    rd(DIVA, d);      chk(d == 16'h0007, "R1 divider", d, 7);

    for (int dv = 0; dv < 3; dv++) begin
      run_burst(1, 1'b1, dv, dv);
      run_burst(3, 1'b0, dv, dv + 40);
      run_burst(2, 1'b0, dv, dv + 80);
      run_burst(7, 1'b1, dv, dv + 120);
    end
    run_burst(0, 1'b1, 0, 5);

    run_burst(2, 1'b0, 1, 9);
    chk(cs_n == 1'b0, "R5 cs held", cs_n, 0);
    r0 = rises;
    wr(CTRL, 16'h4000);
    chk(cs_n == 1'b1, "R6 release", cs_n, 1);
    repeat (20) @(negedge clk);
    rd(CTRL, d);
    chk(rises == r0 && !d[15], "R6 no burst", rises - r0, 0);

    wr(CTRL, 16'h8000 | 16'h4000 | 16'h0001);
    wait_idle();
    rd(CTRL, d);      chk(d[12] && !irq, "R10 masked", {d[12], irq}, 2);
    wr(CTRL, 16'h0000); rd(CTRL, d); chk(d[12] == 1'b1, "R9 write0 keeps", d[12], 1);
    wr(CTRL, 16'h2000); chk(irq == 1'b1, "R10 enable", irq, 1);
    wr(CTRL, 16'h3000); rd(CTRL, d); chk(!d[12] && !irq, "R9 w1c", {d[12], irq}, 0);

    wr(DIVA, 3);
    for (int i = 0; i < 4; i++) wr(i, 16'hA0 + i);
    r0 = rises;
    wr(CTRL, 16'h8000 | 16'h4000 | 16'h0004);
    wr(1, 16'hEE);
    wr(CTRL, 16'h8000 | 16'h4000 | 16'h0009);
    wr(CTRL, 16'h4000);
    wr(DIVA, 0);
    chk(cs_n == 1'b0, "R11 release ignored", cs_n, 0);
    wait_idle();
    chk(rises - r0 == 32, "R11 restart ignored", rises - r0, 32);
    chk(t_last - t_prev == 8, "R11 R8 divider frozen", t_last - t_prev, 8);
    rd(1, d);
    chk(d == {8'h0, g(1)}, "R11 buffer locked", d, g(1));
    chk(cs_n == 1'b1, "R5 final release", cs_n, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule